// File: doc/BRIEF.md
# Piecewise Exponential Envelope Generator

This block shapes an amplitude envelope for a sound voice. A level gate starts a rising phase. In that phase the level climbs by one step at a fixed rate until it reaches full scale. The block then falls toward a programmable hold level and stays there while the gate stays high. When the gate goes low, the level falls back to zero. Each phase takes its speed from its own 4-bit rate code. A rate code picks a base step period from a 16-entry table.

In the default linear mode, the falling phases cannot use a single step rate. At each of five fixed level thresholds the step period doubles again. The falling slope becomes shallower as the level drops, so the fall traces a piecewise-linear curve that approximates an exponential. As an alternative, a shift-based mode removes a fixed fraction of the level on every step. That mode keeps extra fraction bits under the visible level, so the fall still ends at zero.

Top module: `env_shaper`

## Requirements
- R1: After synchronous reset the level is 0 and the block is idle.
- R2: A high gate while idle or releasing starts the rise from the current level. During the rise the level grows by exactly 1 once every P cycles, where P = (rate+1)*(rate+1)*UNIT for the rise rate code. The first step lands P cycles after the edge that entered the rise.
- R3: When the rise reaches 255, the block moves to the fall-to-hold phase on that same edge.
- R4: In linear mode (shift select 0), each falling step lowers the level by 1. The step comes P << k cycles after the previous step or phase entry, where k is the count of thresholds {93, 54, 26, 14, 6} that are at or above the current level.
- R5: The fall toward the hold level stops exactly at that level, which is never undershot. The level then stays constant while the gate remains high.
- R6: A low gate in any active phase starts the release toward 0. On reaching 0 the block goes idle, and the level stays 0 while the gate stays low.
- R7: The edge that sees a gate change only switches phase and restarts the step timer. The level is not changed on that edge.
- R8: The level never wraps. The rise clamps at 255, and the falls clamp at their target. A hold level of 255 keeps the output at 255.
- R9: With shift select s in 1..3, each falling step subtracts max(acc >> s, 1) from an accumulator that holds GUARD_W fraction bits below the visible level. The step period is the base P with no threshold doubling, and the release reaches exactly 0.
- R10: The rise uses the rise rate code. The fall-to-hold and hold phases use the fall rate code. Release and idle use the release rate code. The period is re-evaluated every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | High holds the note on, low releases it |
| atk_rate | input | RATE_W | Rise rate code |
| dec_rate | input | RATE_W | Fall-to-hold rate code |
| rel_rate | input | RATE_W | Release rate code |
| sustain | input | LVL_W | Hold level |
| mul_shift | input | 2 | 0 selects linear falls, 1..3 selects the shift-based fall with that shift |
| level | output | LVL_W | Registered envelope level |

## Verification
The bench builds the block with UNIT=1, LVL_W=8, GUARD_W=4 and RATE_W=4. With UNIT=1 a rate code of 0 gives a one-cycle step, so a full rise, a complete fall through all five thresholds and a shift-based release to zero each take only hundreds of cycles. This puts every threshold crossing, the saturation points and the end of the release within exact cycle-count checks. Random segments use rate codes 0..3, random hold levels, random shift selects and random gate lengths. These segments retrigger the block while it is rising, falling and releasing, and the retrigger often starts from a level that still carries fraction bits.

// File: rtl/env_pkg.sv
package env_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ATTACK  = 3'd1,
    PH_DECAY   = 3'd2,
    PH_SUSTAIN = 3'd3,
    PH_RELEASE = 3'd4
  } phase_e;

  // Level thresholds at or below which the falling step period doubles again.
  localparam int NUM_BP = 5;
  localparam int BP_LEVELS [NUM_BP] = '{93, 54, 26, 14, 6};

  // Base step period for a rate code.
  function automatic int unsigned base_period(input int unsigned rate, input int unsigned unit);
    return (rate + 1) * (rate + 1) * unit;
  endfunction

endpackage

// File: rtl/env_step_timer.sv
module env_step_timer
  import env_pkg::*;
#(
  parameter int RATE_W = 4,
  parameter int LVL_W  = 8,
  parameter int UNIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              bp_en,
  input  logic [RATE_W-1:0] rate,
  input  logic [LVL_W-1:0]  level,
  output logic              tick
);
  localparam int RATE_N   = 1 << RATE_W;
  localparam int MAX_BASE = RATE_N * RATE_N * UNIT;
  localparam int PER_W    = $clog2(MAX_BASE + 1) + NUM_BP;
  localparam int HIT_W    = $clog2(NUM_BP + 1);

  logic [PER_W-1:0] base_tab [RATE_N];
  logic [NUM_BP-1:0] hit;
  logic [HIT_W-1:0]  n_hit;
  logic [PER_W-1:0]  period;
  logic [PER_W-1:0]  cnt_q;

  for (genvar g = 0; g < RATE_N; g++) begin : g_tab
    assign base_tab[g] = PER_W'(base_period(g, UNIT));
  end

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    assign hit[b] = bp_en && (int'(level) <= BP_LEVELS[b]);
  end

  always_comb begin
    n_hit = '0;
    for (int i = 0; i < NUM_BP; i++) n_hit = n_hit + HIT_W'(hit[i]);
    period = base_tab[rate] << n_hit;
  end

  assign tick = (cnt_q >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R4: a fall below the lowest threshold uses the longest step period
  p_deep_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (bp_en && int'(level) <= BP_LEVELS[NUM_BP-1]) |-> (n_hit == HIT_W'(NUM_BP)));

endmodule

// File: rtl/env_level_path.sv
module env_level_path
  import env_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int GUARD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  input  logic             step,
  input  logic [1:0]       mul_shift,
  input  logic [LVL_W-1:0] sustain,
  output logic [LVL_W-1:0] level,
  output logic             done
);
  localparam int ACC_W = LVL_W + GUARD_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {{LVL_W{1'b1}}, {GUARD_W{1'b0}}};
  localparam logic [ACC_W-1:0] ONE_LSB = ACC_W'(1) << GUARD_W;

  logic [ACC_W-1:0] acc_q, acc_nxt, tgt, dec, shifted;
  logic [ACC_W:0]   up;

  assign up      = {1'b0, acc_q} + {1'b0, ONE_LSB};
  assign shifted = acc_q >> mul_shift;
  assign tgt     = (phase == PH_DECAY) ? {sustain, {GUARD_W{1'b0}}} : '0;

  always_comb begin
    if (mul_shift == 2'd0)      dec = ONE_LSB;
    else if (shifted == '0)     dec = ACC_W'(1);
    else                        dec = shifted;
  end

  always_comb begin
    acc_nxt = acc_q;
    done    = 1'b0;
    if (step) begin
      case (phase)
        PH_ATTACK: begin
          acc_nxt = (up >= {1'b0, ACC_MAX}) ? ACC_MAX : up[ACC_W-1:0];
          done    = (acc_nxt == ACC_MAX);
        end
        PH_DECAY, PH_RELEASE: begin
          if (acc_q <= tgt)             acc_nxt = acc_q;
          else if (acc_q - tgt > dec)   acc_nxt = acc_q - dec;
          else                          acc_nxt = tgt;
          done = (acc_nxt <= tgt);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nxt;
  end

  assign level = acc_q[ACC_W-1:GUARD_W];

  // R2: a rising step adds at most one visible count and never lowers the level
  p_rise_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_ATTACK) |=>
      (level >= $past(level)) && ({1'b0, level} <= {1'b0, $past(level)} + 1'b1));

  // R8: a falling step never raises the level (no wrap below zero)
  p_fall_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (step && (phase == PH_DECAY || phase == PH_RELEASE)) |=> (level <= $past(level)));

  // R5: the fall toward the hold level never undershoots it
  p_hold_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_DECAY) |=> (acc_q >= $past(tgt)) || (acc_q == $past(acc_q)));

  // R5: hold and idle phases leave the accumulator untouched
  p_hold_still_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SUSTAIN || phase == PH_IDLE) |=> $stable(acc_q));

endmodule

// File: rtl/env_phase_ctrl.sv
module env_phase_ctrl
  import env_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   gate,
  input  logic   done,
  output phase_e phase,
  output logic   gate_chg,
  output logic   restart
);
  phase_e phase_q, phase_nxt;

  always_comb begin
    if (gate) gate_chg = (phase_q == PH_IDLE) || (phase_q == PH_RELEASE);
    else      gate_chg = (phase_q == PH_ATTACK) || (phase_q == PH_DECAY) ||
                         (phase_q == PH_SUSTAIN);
  end

  always_comb begin
    phase_nxt = phase_q;
    if (gate_chg) begin
      phase_nxt = gate ? PH_ATTACK : PH_RELEASE;
    end else if (done) begin
      case (phase_q)
        PH_ATTACK:  phase_nxt = PH_DECAY;
        PH_DECAY:   phase_nxt = PH_SUSTAIN;
        PH_RELEASE: phase_nxt = PH_IDLE;
        default:    phase_nxt = phase_q;
      endcase
    end
  end

  assign restart = (phase_nxt != phase_q);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

  assign phase = phase_q;

  // R2: gate high while idle or releasing enters the rise
  p_gate_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (gate && (phase_q == PH_IDLE || phase_q == PH_RELEASE)) |=> (phase_q == PH_ATTACK));

  // R6: gate low during any active phase enters release
  p_gate_release_r6: assert property (@(posedge clk) disable iff (rst)
    (!gate && (phase_q == PH_ATTACK || phase_q == PH_DECAY || phase_q == PH_SUSTAIN))
      |=> (phase_q == PH_RELEASE));

  // R3: a completed rise continues into the fall
  p_rise_end_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ATTACK && done) |=> (phase_q == PH_DECAY));

endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import env_pkg::*;
#(
  parameter int RATE_W  = 4,
  parameter int LVL_W   = 8,
  parameter int GUARD_W = 4,
  parameter int UNIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic [RATE_W-1:0] atk_rate,
  input  logic [RATE_W-1:0] dec_rate,
  input  logic [RATE_W-1:0] rel_rate,
  input  logic [LVL_W-1:0]  sustain,
  input  logic [1:0]        mul_shift,
  output logic [LVL_W-1:0]  level
);
  phase_e            phase;
  logic              gate_chg, restart, done, tick, step, bp_en;
  logic [RATE_W-1:0] rate_sel;

  always_comb begin
    case (phase)
      PH_ATTACK:             rate_sel = atk_rate;
      PH_DECAY, PH_SUSTAIN:  rate_sel = dec_rate;
      default:               rate_sel = rel_rate;
    endcase
  end

  assign bp_en = ((phase == PH_DECAY) || (phase == PH_RELEASE)) && (mul_shift == 2'd0);
  assign step  = tick && !gate_chg;

  env_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .done     (done),
    .phase    (phase),
    .gate_chg (gate_chg),
    .restart  (restart)
  );

  env_step_timer #(
    .RATE_W (RATE_W),
    .LVL_W  (LVL_W),
    .UNIT   (UNIT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .bp_en   (bp_en),
    .rate    (rate_sel),
    .level   (level),
    .tick    (tick)
  );

  env_level_path #(
    .LVL_W   (LVL_W),
    .GUARD_W (GUARD_W)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .step      (step),
    .mul_shift (mul_shift),
    .sustain   (sustain),
    .level     (level),
    .done      (done)
  );

  // R6: idle always means the envelope is fully down
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (level == '0));

  // R7: the edge that reacts to a gate change leaves the level alone
  p_gate_edge_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    gate_chg |=> $stable(level));

endmodule

// File: tb/env_shaper_bench.sv
module env_shaper_bench;
  localparam int RATE_W  = 4;
  localparam int LVL_W   = 8;
  localparam int GUARD_W = 4;
  localparam int UNIT    = 1;
  localparam int MAXA    = 255 << GUARD_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              gate = 1'b0;
  logic [RATE_W-1:0] atk_rate = '0, dec_rate = '0, rel_rate = '0;
  logic [LVL_W-1:0]  sustain = '0;
  logic [1:0]        mul_shift = '0;
  logic [LVL_W-1:0]  level;

  int checks = 0, errors = 0, jnow = 0;
  bit mon_en = 1'b0;
  int m_ph = 0, m_acc = 0, m_cnt = 0;

  always #5 clk = ~clk;

  env_shaper #(.RATE_W(RATE_W), .LVL_W(LVL_W), .GUARD_W(GUARD_W), .UNIT(UNIT)) u_env_shaper (
    .clk(clk), .rst(rst), .gate(gate), .atk_rate(atk_rate), .dec_rate(dec_rate),
    .rel_rate(rel_rate), .sustain(sustain), .mul_shift(mul_shift), .level(level)
  );

  function automatic int kcount(input int lv);
    int c = 0;
    if (lv <= 93) c++;
    if (lv <= 54) c++;
    if (lv <= 26) c++;
    if (lv <= 14) c++;
    if (lv <= 6)  c++;
    return c;
  endfunction

  function automatic int fall_cycles(input int from, input int to, input int p);
    int s = 0;
    for (int l = from; l > to; l--) s += p << kcount(l);
    return s;
  endfunction

  function automatic int shift_fall(input int start, input int n, input int sh);
    int a = start;
    for (int i = 0; i < n; i++) begin
      int d = a >> sh;
      if (d < 1) d = 1;
      a = (a > d) ? a - d : 0;
    end
    return a;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic start_edge();
    @(negedge clk);
    jnow = 0;
  endtask

  task automatic advance_to(input int j);
    repeat (j - jnow) @(negedge clk);
    jnow = j;
  endtask

  // Per-cycle reference built from the requirements (R2, R4, R9, R10)
  always @(posedge clk) begin
    int r, p, tgt, d;
    bit tk, gc;
    if (rst) begin
      m_ph = 0; m_acc = 0; m_cnt = 0;
    end else begin
      r = (m_ph == 1) ? int'(atk_rate) : ((m_ph == 2 || m_ph == 3) ? int'(dec_rate) : int'(rel_rate));
      p = (r + 1) * (r + 1) * UNIT;
      if ((m_ph == 2 || m_ph == 4) && mul_shift == 0) p = p << kcount(m_acc >> GUARD_W);
      tk = (m_cnt >= p - 1);
      gc = gate ? (m_ph == 0 || m_ph == 4) : (m_ph >= 1 && m_ph <= 3);
      if (gc) begin
        m_ph = gate ? 1 : 4; m_cnt = 0;
      end else if (tk) begin
        m_cnt = 0;
        if (m_ph == 1) begin
          m_acc = m_acc + (1 << GUARD_W);
          if (m_acc >= MAXA) begin m_acc = MAXA; m_ph = 2; end
        end else if (m_ph == 2 || m_ph == 4) begin
          tgt = (m_ph == 2) ? (int'(sustain) << GUARD_W) : 0;
          d = (mul_shift == 0) ? (1 << GUARD_W) : (m_acc >> mul_shift);
          if (d < 1) d = 1;
          if (m_acc > tgt) m_acc = (m_acc - d > tgt) ? m_acc - d : tgt;
          if (m_acc <= tgt) m_ph = (m_ph == 2) ? 3 : 0;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      string tag;
      case (m_ph)
        1: tag = "R2 model rise";
        2: tag = (mul_shift != 0) ? "R9 model fall" : "R4 model fall";
        3: tag = "R5 model hold";
        4: tag = (mul_shift != 0) ? "R9 model release" : "R10 model release";
        default: tag = "R6 model idle";
      endcase
      chk(tag, int'(level), m_acc >> GUARD_W);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t, n;
    void'($urandom(32'd20061214));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset level", int'(level), 0);
    mon_en = 1'b1;

    // Rise with P=4, then fall to hold 40 at P=1 through the thresholds
    atk_rate = 4'd1; dec_rate = 4'd0; rel_rate = 4'd0; sustain = 8'd40; mul_shift = 2'd0;
    gate = 1'b1;
    start_edge();
    advance_to(39);   chk("R2 rise before step 10", int'(level), 9);
    advance_to(40);   chk("R2 rise step 10", int'(level), 10);
    advance_to(1019); chk("R3 rise just below top", int'(level), 254);
    advance_to(1020); chk("R3 rise reaches top", int'(level), 255);
    t = 1020 + fall_cycles(255, 40, 1);
    advance_to(t - 1); chk("R4 fall one before hold", int'(level), 41);
    advance_to(t);     chk("R5 fall lands on hold", int'(level), 40);
    advance_to(t + 300); chk("R5 hold stays", int'(level), 40);

    // Release from hold
    gate = 1'b0;
    start_edge();
    chk("R7 gate edge keeps level", int'(level), 40);
    t = fall_cycles(40, 0, 1);
    advance_to(t - 1); chk("R6 release one above zero", int'(level), 1);
    advance_to(t);     chk("R6 release reaches zero", int'(level), 0);
    advance_to(t + 200); chk("R6 idle stays zero", int'(level), 0);

    // Release in mid-rise with a slower release rate
    atk_rate = 4'd0; rel_rate = 4'd2;
    gate = 1'b1;
    start_edge();
    advance_to(100); chk("R2 fast rise", int'(level), 100);
    gate = 1'b0;
    start_edge();
    chk("R7 mid-rise drop keeps level", int'(level), 100);
    advance_to(8); chk("R10 release rate before step", int'(level), 100);
    advance_to(9); chk("R10 release rate step", int'(level), 99);
    advance_to(fall_cycles(100, 0, 9)); chk("R6 slow release ends", int'(level), 0);

    // Hold at full scale, then shift-based release
    sustain = 8'd255; rel_rate = 4'd0;
    gate = 1'b1;
    start_edge();
    advance_to(255); chk("R8 rise clamps at top", int'(level), 255);
    advance_to(560); chk("R8 full-scale hold", int'(level), 255);
    mul_shift = 2'd2;
    gate = 1'b0;
    start_edge();
    n = 0;
    while (shift_fall(MAXA, n, 2) != 0) n++;
    advance_to(3);  chk("R9 shift fall step 3", int'(level), shift_fall(MAXA, 3, 2) >> GUARD_W);
    advance_to(10); chk("R9 shift fall step 10", int'(level), shift_fall(MAXA, 10, 2) >> GUARD_W);
    advance_to(n);  chk("R9 shift fall reaches zero", int'(level), 0);
    advance_to(n + 50); chk("R9 stays zero", int'(level), 0);

    // Random segments checked against the reference every cycle
    for (int seg = 0; seg < 60; seg++) begin
      @(negedge clk);
      atk_rate  = RATE_W'($urandom_range(3, 0));
      dec_rate  = RATE_W'($urandom_range(3, 0));
      rel_rate  = RATE_W'($urandom_range(3, 0));
      sustain   = LVL_W'($urandom_range(255, 0));
      mul_shift = 2'($urandom_range(3, 0));
      gate      = ($urandom_range(3, 0) != 0);
      repeat ($urandom_range(400, 1)) @(negedge clk);
    end

    mon_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule